// File: doc/BRIEF.md
# Stack Core ALU Logic and Arithmetic Unit

A purely combinational execution unit for a small stack-oriented processor core. It takes two operand words, a small signed immediate and a 5-bit operation code, and returns one result word in the same cycle. There is no clock, state or flag output. Operand fetch, stack handling and any pipelining belong to the surrounding core.

The unit has three groups of operations:

- **Single-operand:** bitwise NOT and three whole-word reductions (AND, OR, XOR). Each reduction returns a full word of ones or of zeros, not a single bit, so the result can feed a zero-test branch directly.
- **Two-operand:** bitwise logic, add and subtract, an add with a 6-bit signed immediate, and a multiply.
- **Extended forms:** add, subtract and multiply also come in signed and unsigned variants. These return the upper word of the full-precision result. A program chains them with the plain form to build wider arithmetic.

Top module: `alu_unit`

## Requirements
- R1: Operation codes on `op_sel` are:
  - 0 NOT, 1 AND-reduce, 2 OR-reduce, 3 XOR-reduce
  - 4 AND, 5 OR, 6 XOR
  - 8 add, 9 signed-extended add, 10 unsigned-extended add, 11 add-immediate
  - 12 subtract, 13 signed-extended subtract, 14 unsigned-extended subtract
  - 16 multiply, 17 signed-extended multiply, 18 unsigned-extended multiply

  Every other code (7, 15, 19 to 31) yields a zero result.
- R2: NOT returns the bitwise complement of `opd_a`; for example 0x36C9A53C gives 0xC9365AC3.
- R3: AND, OR and XOR combine `opd_a` and `opd_b` bit by bit; for 0x36C9A53C and 0x5CA3C396 they give 0x14818114, 0x7EEBE7BE and 0x6A6A66AA.
- R4: The reductions of `opd_a` return all-ones when true and zero when false:
  - AND-reduce is true only for all-ones.
  - OR-reduce is true for any nonzero word.
  - XOR-reduce is true for an odd count of set bits.
- R5: Add and subtract return the low word of `opd_a + opd_b` and `opd_a - opd_b`, wrapping modulo 2^32.
- R6: Add-immediate sign-extends the 6-bit `imm` (range -32 to +31) and adds it to `opd_a`; for example 0xA53C36C9 with -32 gives 0xA53C36A9.
- R7: The signed-extended add and subtract treat both operands as two's complement. They return the upper word of the 33-bit result, which is always 0 or 0xFFFFFFFF.
- R8: The unsigned-extended forms treat both operands as unsigned:
  - Add returns the carry as 0 or 1.
  - Subtract returns the borrow as 0 or 0xFFFFFFFF, with all-ones exactly when `opd_a < opd_b`.
- R9: Multiply returns the low word of the 64-bit product.
- R10: The signed-extended multiply returns the upper word of the 64-bit two's-complement product.
- R11: The unsigned-extended multiply returns the upper word of the 64-bit unsigned product.
- R12: The result depends only on the current inputs with no clock. `imm` has no effect on any operation other than add-immediate, and `opd_b` has no effect on the single-operand operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see R1) |
| opd_a | input | 32 | First operand, the only one used by unary operations |
| opd_b | input | 32 | Second operand |
| imm | input | 6 | Signed immediate for add-immediate |
| result | output | 32 | Operation result, valid in the same cycle |

## Verification
The checker evaluates its properties only when the operation code and operands carry no unknown bits, because a combinational unit has no reset to qualify them. It therefore takes for granted that the surrounding core presents fully known values whenever it reads the result. The stimulus drives every input to a defined value from time zero, changes inputs only on the falling clock edge, and samples the result a nanosecond later. Every operation code, including the undefined ones, is applied under fully known operands.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [4:0] {
    OP_NOT   = 5'd0,
    OP_RAND  = 5'd1,
    OP_ROR   = 5'd2,
    OP_RXOR  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_ADD   = 5'd8,
    OP_ADDSX = 5'd9,
    OP_ADDUX = 5'd10,
    OP_ADDI  = 5'd11,
    OP_SUB   = 5'd12,
    OP_SUBSX = 5'd13,
    OP_SUBUX = 5'd14,
    OP_MUL   = 5'd16,
    OP_MULSX = 5'd17,
    OP_MULUX = 5'd18
  } alu_op_e;
endpackage

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise and whole-word reduction operations.
module alu_logic import alu_pkg::*; #(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  logic [W-1:0] and_v, or_v, xor_v, not_v;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign and_v[i] = a[i] & b[i];
    assign or_v[i]  = a[i] | b[i];
    assign xor_v[i] = a[i] ^ b[i];
    assign not_v[i] = ~a[i];
  end

  always_comb begin
    unique case (op)
      OP_NOT:  y = not_v;
      OP_RAND: y = {W{&a}};
      OP_ROR:  y = {W{|a}};
      OP_RXOR: y = {W{^a}};
      OP_AND:  y = and_v;
      OP_OR:   y = or_v;
      OP_XOR:  y = xor_v;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Adder/subtractor. One unsigned W+1 bit adder per direction; the signed
// extension word is derived from its top bit and the operand sign bits.
module alu_addsub import alu_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [IW-1:0]  imm,
  output logic [W-1:0]   y
);
  localparam int XW = W + 1;

  logic [XW-1:0] sum_u, dif_u;
  logic [W-1:0]  imm_x, sum_i;
  logic          sgn_add, sgn_sub;

  assign sum_u   = {1'b0, a} + {1'b0, b};
  assign dif_u   = {1'b0, a} - {1'b0, b};
  // bit W of the sign-extended sum = a_msb ^ b_msb ^ unsigned top bit
  assign sgn_add = a[W-1] ^ b[W-1] ^ sum_u[W];
  assign sgn_sub = a[W-1] ^ b[W-1] ^ dif_u[W];
  assign imm_x   = {{(W-IW){imm[IW-1]}}, imm};
  assign sum_i   = a + imm_x;

  always_comb begin
    unique case (op)
      OP_ADD:   y = sum_u[W-1:0];
      OP_ADDSX: y = {W{sgn_add}};
      OP_ADDUX: y = {{(W-1){1'b0}}, sum_u[W]};
      OP_ADDI:  y = sum_i;
      OP_SUB:   y = dif_u[W-1:0];
      OP_SUBSX: y = {W{sgn_sub}};
      OP_SUBUX: y = {W{dif_u[W]}};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
// Single unsigned W x W multiplier; the signed upper word is corrected from it.
module alu_mul import alu_pkg::*; #(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod_u;
  logic [W-1:0]  hi_u, hi_s, corr_a, corr_b;

  assign prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign hi_u   = prod_u[PW-1:W];
  assign corr_a = a[W-1] ? b : '0;
  assign corr_b = b[W-1] ? a : '0;
  assign hi_s   = hi_u - corr_a - corr_b;

  always_comb begin
    unique case (op)
      OP_MUL:   y = prod_u[W-1:0];
      OP_MULSX: y = hi_s;
      OP_MULUX: y = hi_u;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/alu_unit.sv
`timescale 1ns/1ps
module alu_unit import alu_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input  logic [4:0]    op_sel,
  input  logic [W-1:0]  opd_a,
  input  logic [W-1:0]  opd_b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  result
);
  alu_op_e      op;
  logic [W-1:0] y_log, y_add, y_mul;

  assign op = alu_op_e'(op_sel);

  alu_logic #(.W(W)) u_logic (
    .op(op), .a(opd_a), .b(opd_b), .y(y_log)
  );

  alu_addsub #(.W(W), .IW(IW)) u_addsub (
    .op(op), .a(opd_a), .b(opd_b), .imm(imm), .y(y_add)
  );

  alu_mul #(.W(W)) u_mul (
    .op(op), .a(opd_a), .b(opd_b), .y(y_mul)
  );

  // group select from the top two code bits; units zero unknown codes
  always_comb begin
    unique case (op_sel[4:3])
      2'b00:   result = y_log;
      2'b01:   result = y_add;
      2'b10:   result = y_mul;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/alu_unit_chk.sv
`timescale 1ns/1ps
module alu_unit_chk import alu_pkg::*; #(
  parameter int W  = 32,
  parameter int IW = 6
) (
  input logic [4:0]    op_sel,
  input logic [W-1:0]  opd_a,
  input logic [W-1:0]  opd_b,
  input logic [IW-1:0] imm,
  input logic [W-1:0]  result
);
  logic          known;
  logic [W-1:0]  imm_sx;

  assign known  = !$isunknown({op_sel, opd_a, opd_b, imm});
  assign imm_sx = W'($signed(imm));

  always_comb begin
    if (known) begin
      if (op_sel == 5'd7 || op_sel == 5'd15 || op_sel > 5'd18)
        AST_UNDEF_ZERO: assert (result == '0);                                   // R1
      if (op_sel == OP_NOT)
        AST_NOT_DISJOINT: assert ((result & opd_a) == '0 && (result | opd_a) == '1); // R2
      if (op_sel == OP_AND)
        AST_AND_SUBSET: assert ((result & ~opd_a) == '0 && (result & ~opd_b) == '0); // R3
      if (op_sel == OP_OR)
        AST_OR_SUPERSET: assert ((~result & (opd_a | opd_b)) == '0);             // R3
      if (op_sel inside {OP_RAND, OP_ROR, OP_RXOR})
        AST_RED_FULLWORD: assert ($countones(result) == 0 || $countones(result) == W); // R4
      if (op_sel == OP_ADDI)
        AST_ADDI_DELTA: assert (result - opd_a == imm_sx);                       // R6
      if (op_sel == OP_SUB)
        AST_SUB_INVERSE: assert (result + opd_b == opd_a);                       // R5
      if (op_sel inside {OP_ADDSX, OP_SUBSX, OP_SUBUX})
        AST_EXT_SIGNWORD: assert (result == '0 || result == '1);                 // R7
      if (op_sel == OP_ADDUX)
        AST_CARRY_BIT: assert (result <= W'(1));                                 // R8
      if (op_sel == OP_SUBUX)
        AST_BORROW_CMP: assert ((result != '0) == (opd_a < opd_b));              // R8
    end
  end
endmodule

bind alu_unit alu_unit_chk #(.W(W), .IW(IW)) u_chk (
  .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b), .imm(imm), .result(result)
);

// File: tb/alu_unit_test.sv
`timescale 1ns/1ps
module alu_unit_test;
  logic        clk;
  logic        rst_n;
  logic [4:0]  op_sel;
  logic [31:0] opd_a, opd_b, result;
  logic [5:0]  imm;
  int          n_chk, n_err;

  alu_unit uut (
    .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b), .imm(imm), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_model(input logic [4:0] op, input logic [31:0] a,
                                             input logic [31:0] b, input logic [5:0] im);
    logic [63:0] ua, ub, sa, sb, t;
    int ones;
    ua = {32'd0, a}; ub = {32'd0, b};
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    ones = 0;
    for (int k = 0; k < 32; k++) ones += a[k];
    case (op)
      5'd0:  return ~a;
      5'd1:  return (a == 32'hFFFFFFFF) ? 32'hFFFFFFFF : 32'h0;
      5'd2:  return (a != 0) ? 32'hFFFFFFFF : 32'h0;
      5'd3:  return (ones % 2 == 1) ? 32'hFFFFFFFF : 32'h0;
      5'd4:  return a & b;
      5'd5:  return a | b;
      5'd6:  return a ^ b;
      5'd8:  return a + b;
      5'd9:  begin t = sa + sb; return t[63:32]; end
      5'd10: begin t = ua + ub; return t[63:32]; end
      5'd11: return a + {{26{im[5]}}, im};
      5'd12: return a - b;
      5'd13: begin t = sa - sb; return t[63:32]; end
      5'd14: begin t = ua - ub; return t[63:32]; end
      5'd16: begin t = ua * ub; return t[31:0]; end
      5'd17: begin t = sa * sb; return t[63:32]; end
      5'd18: begin t = ua * ub; return t[63:32]; end
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0: return "R2";
      5'd1, 5'd2, 5'd3: return "R4";
      5'd4, 5'd5, 5'd6: return "R3";
      5'd8, 5'd12: return "R5";
      5'd11: return "R6";
      5'd9, 5'd13: return "R7";
      5'd10, 5'd14: return "R8";
      5'd16: return "R9";
      5'd17: return "R10";
      5'd18: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic apply_chk(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [5:0] im, input logic [31:0] exp, input string tag);
    @(negedge clk);
    op_sel = op; opd_a = a; opd_b = b; imm = im;
    #1;
    n_chk++;
    if (result !== exp) begin
      n_err++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h actual=%h expected=%h",
               tag, op, a, b, im, result, exp);
    end
  endtask

  task automatic t_reset_state();
    // inputs held at zero through reset: NOT of zero is all-ones (R2)
    n_chk++;
    if (result !== 32'hFFFFFFFF) begin
      n_err++;
      $display("FAIL R2 reset-state actual=%h expected=%h", result, 32'hFFFFFFFF);
    end
  endtask

  task automatic t_logic();
    apply_chk(5'd0, 32'h36C9A53C, 32'h0, 6'd0, 32'hC9365AC3, "R2");
    apply_chk(5'd4, 32'h36C9A53C, 32'h5CA3C396, 6'd0, 32'h14818114, "R3");
    apply_chk(5'd5, 32'h36C9A53C, 32'h5CA3C396, 6'd0, 32'h7EEBE7BE, "R3");
    apply_chk(5'd6, 32'h36C9A53C, 32'h5CA3C396, 6'd0, 32'h6A6A66AA, "R3");
  endtask

  task automatic t_reduce();
    apply_chk(5'd1, 32'hFFFFFFFF, 32'h0, 6'd0, 32'hFFFFFFFF, "R4");
    apply_chk(5'd1, 32'h00000001, 32'h0, 6'd0, 32'h0, "R4");
    apply_chk(5'd2, 32'h00000001, 32'h0, 6'd0, 32'hFFFFFFFF, "R4");
    apply_chk(5'd2, 32'hFFFFFFFF, 32'h0, 6'd0, 32'hFFFFFFFF, "R4");
    apply_chk(5'd2, 32'h0, 32'hFFFFFFFF, 6'd0, 32'h0, "R4");
    apply_chk(5'd3, 32'h00000001, 32'h0, 6'd0, 32'hFFFFFFFF, "R4");
    apply_chk(5'd3, 32'hFFFFFFFF, 32'h0, 6'd0, 32'h0, "R4");
  endtask

  task automatic t_addsub();
    apply_chk(5'd8, 32'hFFFFFFFF, 32'h1, 6'd0, 32'h0, "R5");
    apply_chk(5'd12, 32'h0, 32'h1, 6'd0, 32'hFFFFFFFF, "R5");
    apply_chk(5'd11, 32'hA53C36C9, 32'h0, 6'h20, 32'hA53C36A9, "R6");
    apply_chk(5'd11, 32'hA53C36A9, 32'h0, 6'd31, 32'hA53C36C8, "R6");
    apply_chk(5'd11, 32'hFFFFFFFF, 32'h0, 6'd1, 32'h0, "R6");
  endtask

  task automatic t_extended();
    apply_chk(5'd9, 32'h80000000, 32'h80000000, 6'd0, 32'hFFFFFFFF, "R7");
    apply_chk(5'd9, 32'h7FFFFFFF, 32'h1, 6'd0, 32'h0, "R7");
    apply_chk(5'd9, 32'hFFFFFFFF, 32'h1, 6'd0, 32'h0, "R7");
    apply_chk(5'd13, 32'h0, 32'h1, 6'd0, 32'hFFFFFFFF, "R7");
    apply_chk(5'd13, 32'h7FFFFFFF, 32'hFFFFFFFF, 6'd0, 32'h0, "R7");
    apply_chk(5'd10, 32'hFFFFFFFF, 32'h1, 6'd0, 32'h1, "R8");
    apply_chk(5'd10, 32'h7FFFFFFF, 32'h1, 6'd0, 32'h0, "R8");
    apply_chk(5'd14, 32'h0, 32'h1, 6'd0, 32'hFFFFFFFF, "R8");
    apply_chk(5'd14, 32'h5, 32'h5, 6'd0, 32'h0, "R8");
  endtask

  task automatic t_mul();
    apply_chk(5'd16, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd0, 32'h1, "R9");
    apply_chk(5'd17, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd0, 32'h0, "R10");
    apply_chk(5'd17, 32'h80000000, 32'h2, 6'd0, 32'hFFFFFFFF, "R10");
    apply_chk(5'd18, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'd0, 32'hFFFFFFFE, "R11");
    apply_chk(5'd16, 32'h36C9A53C, 32'h5CA3C396, 6'd0,
              ref_model(5'd16, 32'h36C9A53C, 32'h5CA3C396, 6'd0), "R9");
  endtask

  task automatic t_undefined();
    apply_chk(5'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h3F, 32'h0, "R1");
    apply_chk(5'd15, 32'hFFFFFFFF, 32'h1, 6'h3F, 32'h0, "R1");
    apply_chk(5'd19, 32'hFFFFFFFF, 32'hFFFFFFFF, 6'h3F, 32'h0, "R1");
    apply_chk(5'd31, 32'h12345678, 32'h9ABCDEF0, 6'h3F, 32'h0, "R1");
  endtask

  task automatic t_ignored_inputs();
    // R12: imm must not affect add; opd_b must not affect NOT or reductions
    apply_chk(5'd8, 32'h10, 32'h20, 6'h00, 32'h30, "R12");
    apply_chk(5'd8, 32'h10, 32'h20, 6'h3F, 32'h30, "R12");
    apply_chk(5'd0, 32'h0000FFFF, 32'hDEADBEEF, 6'h15, 32'hFFFF0000, "R12");
    apply_chk(5'd2, 32'h0, 32'hFFFFFFFF, 6'h1F, 32'h0, "R12");
  endtask

  task automatic t_sweep();
    logic [31:0] x, y;
    x = 32'h36C9A53C; y = 32'h5CA3C396;
    for (int n = 0; n < 256; n++) begin
      logic [4:0] op;
      op = 5'(n % 32);
      apply_chk(op, x, y, x[5:0], ref_model(op, x, y, x[5:0]), tag_of(op));
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      y = y ^ (y << 7);  y = y ^ (y >> 9);  y = y + 32'h9E3779B9;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    op_sel = 5'd0; opd_a = 32'h0; opd_b = 32'h0; imm = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_logic();
    t_reduce();
    t_addsub();
    t_extended();
    t_mul();
    t_undefined();
    t_ignored_inputs();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule